// File: doc/BRIEF.md
# Time-Shifted Lockstep Compare Wrapper

This block holds two copies of a small synchronous accumulate unit and checks that they agree. The primary copy works on the live inputs and drives the block's result outputs directly. The redundant copy receives the same inputs after a fixed delay of `DELAY` cycles. The primary copy's outputs are held back by an equal delay and then compared with the redundant copy's outputs on every cycle. Because the two copies process a given operation `DELAY` cycles apart, a single transient upset cannot disturb both copies in the same way in the same cycle. Any disagreement sets a major alert. The alert stays set until reset.

Large storage arrays of the surrounding design are kept outside the duplicated region. They are assumed to be protected by other means, so only the compute logic and its small accumulator are replicated. After reset the comparison is held off until both delay chains have refilled. This keeps the reset contents of the chains from causing false alerts. A diagnostic injection input XORs a pattern onto the redundant copy's compared output only. Integrators use it to prove that the alert path works.

Top module: `lockstep_wrap`

## Requirements
- R1: The accumulator updates on every clock edge where `in_valid_i` is 1. The operation is selected by `op_i`: 2'b00 loads `a_i`; 2'b01 adds `a_i` modulo 2^DW; 2'b10 XORs `a_i` into the accumulator; 2'b11 clears it to zero. `res_o` always shows the primary accumulator.
- R2: `res_o` shows the new value from the edge that accepts the operation. `res_valid_o` is 1 for exactly the cycle that follows each edge where `in_valid_i` was 1.
- R3: While `rst_ni` is low, and right after it is released, `res_o` is 0, `res_valid_o` is 0 and `alert_major_o` is 0.
- R4: The redundant copy receives every input delayed by `DELAY` cycles. With `fault_inj_i` held at zero, no input sequence ever raises `alert_major_o`.
- R5: During the first `DELAY` clock edges after reset release, the comparison is masked. A nonzero `fault_inj_i` in that window has no effect on `alert_major_o`.
- R6: Once the mask has lifted, any cycle in which the delayed primary output differs from the redundant output sets `alert_major_o` at the next edge. The compared word has the valid flag in bit DW and the result in bits DW-1:0. `fault_inj_i` is XORed onto that word on the redundant side.
- R7: `alert_major_o` comes from a register. Once set, it stays 1 until `rst_ni` goes low, and reset clears it.
- R8: `fault_inj_i` has no effect on `res_o` or `res_valid_o`.
- R9: On an edge where `in_valid_i` is 0, the accumulator keeps its value, whatever `op_i` and `a_i` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both copies |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation select (load, add, xor, clear) |
| a_i | input | DW | Operand |
| fault_inj_i | input | DW+1 | Diagnostic pattern XORed onto the redundant compared word |
| res_o | output | DW | Primary accumulator value |
| res_valid_o | output | 1 | Result strobe, one cycle after an accepted operation |
| alert_major_o | output | 1 | Sticky major alert |

## Verification
The bench builds the wrapper with DW=8 and DELAY=3. The narrow width makes add wrap-around happen often under random operands. The three-cycle delay gives a warm-up window wide enough to inject across several masked edges and then hit the first unmasked edge exactly. Injection on the valid bit and on result bits separately confirms that both fields of the compared word are checked.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_ADD  = 2'b01,
    OP_XOR  = 2'b10,
    OP_CLR  = 2'b11
  } ls_op_e;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/ls_delay.sv
module ls_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stg_q [DEPTH];
      logic [W-1:0] stg_d [DEPTH];

      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
          always_comb stg_d[s] = d_i;
        end else begin : g_body
          always_comb stg_d[s] = stg_q[s-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            stg_q[s] <= '0;
          end else begin
            stg_q[s] <= stg_d[s];
          end
        end
      end

      assign q_o = stg_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/ls_unit.sv
module ls_unit
  import lockstep_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  ls_op_e        op_i,
  input  logic [DW-1:0] a_i,
  output logic [DW-1:0] res_o,
  output logic          res_valid_o
);

  logic [DW-1:0] acc_q, acc_d;
  logic          vld_q, vld_d;
  logic          acc_en;

  assign acc_en = in_valid_i;

  always_comb begin
    acc_d = acc_q;
    unique case (op_i)
      OP_LOAD: acc_d = a_i;
      OP_ADD:  acc_d = acc_q + a_i;
      OP_XOR:  acc_d = acc_q ^ a_i;
      OP_CLR:  acc_d = '0;
      default: acc_d = acc_q;
    endcase
    vld_d = in_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign res_o       = acc_q;
  assign res_valid_o = vld_q;

  // R1: a load leaves the operand in the accumulator
  p_load_takes_operand_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_LOAD) |=> (res_o == $past(a_i)));

  // R9: with no strobe the accumulator holds
  p_idle_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i) |=> $stable(res_o));

endmodule

// File: rtl/ls_compare.sv
module ls_compare
  import lockstep_pkg::*;
#(
  parameter int unsigned W     = 9,
  parameter int unsigned DELAY = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] chk_i,
  input  logic [W-1:0] inj_i,
  output logic         alert_o
);

  localparam int unsigned CW = cnt_width(DELAY);
  localparam logic [CW-1:0] CNT_MAX = CW'(DELAY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          armed;
  logic          differ;
  logic          alert_q, alert_d;

  assign armed  = (cnt_q == CNT_MAX);
  assign cnt_en = !armed;
  assign differ = (ref_i != (chk_i ^ inj_i));

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    alert_d = alert_q | (armed & differ);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q <= 1'b0;
    end else begin
      alert_q <= alert_d;
    end
  end

  assign alert_o = alert_q;

  // R5: warm-up counter never passes the delay depth
  p_cnt_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  // R5: no alert can exist while the comparison is still masked
  p_no_alert_warmup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed) |-> (!alert_o));

  // R6: an unmasked disagreement raises the alert at the next edge
  p_mismatch_alerts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && differ) |=> alert_o);

  // R7: the alert is sticky
  p_alert_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> alert_o);

endmodule

// File: rtl/lockstep_wrap.sv
module lockstep_wrap
  import lockstep_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DELAY = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW:0]   fault_inj_i,
  output logic [DW-1:0] res_o,
  output logic          res_valid_o,
  output logic          alert_major_o
);

  localparam int unsigned IN_W  = DW + 3;
  localparam int unsigned OUT_W = DW + 1;

  // primary copy on live inputs
  logic [DW-1:0] pri_res;
  logic          pri_vld;

  ls_unit #(.DW(DW)) u_primary (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .op_i        (ls_op_e'(op_i)),
    .a_i         (a_i),
    .res_o       (pri_res),
    .res_valid_o (pri_vld)
  );

  // input delay toward the redundant copy
  logic [IN_W-1:0] in_live, in_late;
  assign in_live = {in_valid_i, op_i, a_i};

  ls_delay #(.W(IN_W), .DEPTH(DELAY)) u_in_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (in_live),
    .q_o    (in_late)
  );

  logic          red_in_valid;
  logic [1:0]    red_op;
  logic [DW-1:0] red_a;
  assign {red_in_valid, red_op, red_a} = in_late;

  logic [DW-1:0] red_res;
  logic          red_vld;

  ls_unit #(.DW(DW)) u_redundant (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (red_in_valid),
    .op_i        (ls_op_e'(red_op)),
    .a_i         (red_a),
    .res_o       (red_res),
    .res_valid_o (red_vld)
  );

  // output delay on the primary side
  logic [OUT_W-1:0] pri_word, pri_word_late, red_word;
  assign pri_word = {pri_vld, pri_res};
  assign red_word = {red_vld, red_res};

  ls_delay #(.W(OUT_W), .DEPTH(DELAY)) u_out_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pri_word),
    .q_o    (pri_word_late)
  );

  ls_compare #(.W(OUT_W), .DELAY(DELAY)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (pri_word_late),
    .chk_i   (red_word),
    .inj_i   (fault_inj_i),
    .alert_o (alert_major_o)
  );

  assign res_o       = pri_res;
  assign res_valid_o = pri_vld;

  // R2: an accepted operation produces a result strobe one cycle later
  p_strobe_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> res_valid_o);

  // R4: with injection quiet, the alert can only rise if the copies disagree
  p_rise_needs_diff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_major_o) |-> $past((pri_word_late ^ red_word) != fault_inj_i));

endmodule

// File: tb/tb_lockstep_wrap.sv
module tb_lockstep_wrap;

  localparam int DW    = 8;
  localparam int DELAY = 3;
  localparam time CLK_PERIOD = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          in_valid_i;
  logic [1:0]    op_i;
  logic [DW-1:0] a_i;
  logic [DW:0]   fault_inj_i;
  logic [DW-1:0] res_o;
  logic          res_valid_o;
  logic          alert_major_o;

  lockstep_wrap #(.DW(DW), .DELAY(DELAY)) dut (
    .clk_i, .rst_ni, .in_valid_i, .op_i, .a_i, .fault_inj_i,
    .res_o, .res_valid_o, .alert_major_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_acc;
  logic          m_vld;

  function automatic logic [DW-1:0] f_next(logic [DW-1:0] acc, logic v,
                                          logic [1:0] op, logic [DW-1:0] a);
    if (!v) return acc;
    case (op)
      2'b00:   return a;
      2'b01:   return acc + a;
      2'b10:   return acc ^ a;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive, step model, sample result after the edge
  task automatic step(logic v, logic [1:0] op, logic [DW-1:0] a, logic [DW:0] inj);
    in_valid_i  = v;
    op_i        = op;
    a_i         = a;
    fault_inj_i = inj;
    @(posedge clk_i);
    m_acc = f_next(m_acc, v, op, a);
    m_vld = v;
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0; op_i = '0; a_i = '0; fault_inj_i = '0;
    m_acc = '0; m_vld = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R3 res in reset", res_o, 0);
    chk("R3 valid in reset", res_valid_o, 0);
    chk("R3 alert in reset", alert_major_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_random(int n);
    for (int i = 0; i < n; i++) begin
      step(($urandom % 4) != 0, 2'($urandom), DW'($urandom), '0);
      chk("R1 result", res_o, m_acc);
      chk("R2 strobe", res_valid_o, m_vld);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    #1;
    chk("R3 res after release", res_o, 0);
    chk("R3 alert after release", alert_major_o, 0);

    // directed ops: load, add with wrap, xor, idle with noise, clear
    step(1'b1, 2'b00, 8'hF0, '0); chk("R1 load", res_o, 8'hF0);
    chk("R2 strobe after load", res_valid_o, 1);
    step(1'b1, 2'b01, 8'h20, '0); chk("R1 add wraps", res_o, 8'h10);
    step(1'b1, 2'b10, 8'hFF, '0); chk("R1 xor", res_o, 8'hEF);
    step(1'b0, 2'b11, 8'h55, '0); chk("R9 idle holds", res_o, 8'hEF);
    chk("R2 strobe low when idle", res_valid_o, 0);
    step(1'b1, 2'b11, 8'h55, '0); chk("R1 clear", res_o, 0);

    run_random(400);
    chk("R4 no alert fault-free", alert_major_o, 0);

    // R6 / R8: inject on result bits after warm-up
    step(1'b1, 2'b00, 8'h3C, 9'h001);
    chk("R8 result unaffected by injection", res_o, 8'h3C);
    chk("R8 strobe unaffected by injection", res_valid_o, 1);
    chk("R6 alert after result-bit mismatch", alert_major_o, 1);
    run_random(20);
    chk("R7 alert sticky", alert_major_o, 1);

    // R7 reset clears; R5 masked injection across the warm-up window
    do_reset();
    #1;
    chk("R7 reset clears alert", alert_major_o, 0);
    for (int i = 0; i < DELAY; i++) begin
      step(1'b1, 2'($urandom), DW'($urandom), 9'h1FF);
      chk("R5 masked during warm-up", alert_major_o, 0);
    end
    step(1'b0, 2'b00, '0, '0);
    chk("R5 no alert after masked window", alert_major_o, 0);
    run_random(50);
    chk("R4 no alert after second reset", alert_major_o, 0);

    // R5 boundary: inject exactly on the first unmasked edge
    do_reset();
    for (int i = 0; i < DELAY; i++) step(1'b0, 2'b00, '0, '0);
    chk("R5 still clear before first armed edge", alert_major_o, 0);
    step(1'b0, 2'b00, '0, 9'h100);
    chk("R6 alert on valid-bit mismatch at first armed edge", alert_major_o, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule